// File: doc/BRIEF.md
# Host Bus Interface for an 8-bit Microprocessor

This block sits between an 8-bit host processor bus and the command and data registers of a display controller. One set of pins serves two bus styles. A static format input picks between them. The first style has separate active-low read and write strobes. The second has an enable clock and a read/write level. A chip select qualifies every access. A single address line marks each byte as a command or as a parameter/data byte.

The host pins are asynchronous to the controller clock, so they pass through a synchroniser. Each host write then produces exactly one single-cycle internal write pulse when its strobe ends. The pulse carries the byte and its command/data tag. Each host read produces one internal pulse at its trailing edge, so the core can advance its read pointer. During the read, the external data bus is driven straight from the core's read data.

Commands in the memory-transfer class have to wait for a display memory slot. Such a command sets a busy flag, and a slot-done input from the core clears it. Any write that arrives while the flag is set is still forwarded, but it also raises an overrun pulse.

Top module: `hbus_port`

## Requirements
- R1: After reset, `core_wr_stb`, `core_rd_stb`, `busy`, `overrun` and `d_oe` are all 0, and `d_out` is 0.
- R2: With `bus_fmt`=0 (strobe style, `rd_e` = active-low read, `wr_rw` = active-low write), each write with `cs_n` low produces exactly one `core_wr_stb` pulse. The pulse presents `d_in` on `core_wr_data`, and presents `a0` on `core_wr_cmd` (`a0`=1 means command byte).
- R3: With `bus_fmt`=1 (enable style, `rd_e` = E clock active high, `wr_rw` = 1 for read and 0 for write), each period of E high with `wr_rw` low and `cs_n` low produces exactly one `core_wr_stb` pulse with the byte and tag as in R2.
- R4: `d_oe` is 1 exactly while `cs_n` is low and a read is decoded: in strobe style `rd_e` low with `wr_rw` high, and in enable style E high with `wr_rw` high. While `d_oe` is 1, `d_out` equals `core_rd_data`. Otherwise `d_out` is 0.
- R5: Each host read produces exactly one `core_rd_stb` pulse after the read ends, with `core_rd_cmd` equal to the `a0` level held during the read.
- R6: The `core_wr_stb` pulse occurs at the rising edge that comes SYNC_STAGES cycles after the first rising edge that samples the write strobe deasserted.
- R7: While `cs_n` is high, strobe activity produces no `core_wr_stb`, no `core_rd_stb`, and `d_oe` stays 0.
- R8: In strobe style, both strobes low at once is not a transfer: no pulse and no `d_oe`.
- R9: A command byte (`a0`=1) whose upper nibble equals MEM_CLASS (default 4'h4) sets `busy` one cycle after its `core_wr_stb`. `busy` clears on the edge after `mem_slot_done` is sampled high.
- R10: A write whose `core_wr_stb` occurs while `busy` is 1 is still forwarded, and it raises `overrun` for one cycle, one cycle after that pulse.
- R11: A parameter/data byte (`a0`=0) never sets `busy`, whatever its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_fmt | input | 1 | Static bus style: 0 strobe style, 1 enable style |
| cs_n | input | 1 | Active-low chip select |
| a0 | input | 1 | Byte type: 1 command, 0 parameter/data |
| rd_e | input | 1 | Read strobe (strobe style) or E clock (enable style) |
| wr_rw | input | 1 | Write strobe (strobe style) or read/write level (enable style) |
| d_in | input | 8 | Host data bus, inbound |
| d_out | output | 8 | Host data bus, outbound |
| d_oe | output | 1 | Drive enable for the host data bus |
| core_wr_stb | output | 1 | One-cycle internal write pulse |
| core_wr_cmd | output | 1 | Tag of the written byte: 1 command |
| core_wr_data | output | 8 | Written byte |
| core_rd_stb | output | 1 | One-cycle pulse at the end of a host read |
| core_rd_cmd | output | 1 | Address line level of the completed read |
| core_rd_data | input | 8 | Read data supplied by the core |
| mem_slot_done | input | 1 | Display memory slot for the pending transfer completed |
| busy | output | 1 | Memory-transfer command pending |
| overrun | output | 1 | One-cycle flag: a write arrived while busy |

## Verification
The bench sweeps every byte value with both address-line levels in both bus styles.

- For each write it checks the forwarded byte, the tag and the exact pulse latency. A synchroniser depth that is off by one fails the latency check.
- A tag taken from the wrong level mislabels half the sweep.
- Bytes in the memory class are written both as commands and as parameters. A class decode that ignores the address line would set `busy` on parameters.
- The bench writes again while `busy` is set, which catches an overrun that is missing or that drops the byte.
- Strobes under a deasserted chip select, and both strobes low together, must stay silent. A decoder that trusts one strobe alone would emit pulses there.

// File: rtl/hbus_pkg.sv
package hbus_pkg;

    localparam int HB_DW    = 8;
    localparam int HB_CLS_W = 4;

    typedef enum logic {
        FMT_STROBE = 1'b0,
        FMT_ENABLE = 1'b1
    } bus_fmt_e;

    typedef struct packed {
        logic rd;
        logic wr;
    } pin_op_t;

    typedef struct packed {
        logic             is_cmd;
        logic [HB_DW-1:0] data;
    } host_byte_t;

    localparam int HB_BYTE_W = $bits(host_byte_t);

    // Turn the shared pin pair into a read/write decision for one bus style.
    function automatic pin_op_t decode_pins(bus_fmt_e fmt, logic cs_n, logic pa, logic pb);
        pin_op_t op;
        op = '0;
        if (!cs_n) begin
            if (fmt == FMT_STROBE) begin
                op.rd = !pa && pb;
                op.wr = pa && !pb;
            end else begin
                op.rd = pa && pb;
                op.wr = pa && !pb;
            end
        end
        return op;
    endfunction

    // Command byte belonging to the memory-transfer class.
    function automatic logic is_mem_cmd(host_byte_t b, logic [HB_CLS_W-1:0] cls);
        return b.is_cmd && (b.data[HB_DW-1 -: HB_CLS_W] == cls);
    endfunction

endpackage

// File: rtl/hbus_sync.sv
module hbus_sync #(
    parameter int             W       = 1,
    parameter int             STAGES  = 2,
    parameter logic [W-1:0]   RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [STAGES-1:0][W-1:0] chain;

    always_ff @(posedge clk) begin
        if (rst) begin
            chain <= {STAGES{RST_VAL}};
        end else begin
            chain[0] <= d;
            for (int i = 1; i < STAGES; i++) begin
                chain[i] <= chain[i-1];
            end
        end
    end

    assign q = chain[STAGES-1];
endmodule

// File: rtl/hbus_edge_cap.sv
module hbus_edge_cap
    import hbus_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  pin_op_t    op_s,
    input  host_byte_t byte_s,
    output logic       wr_stb,
    output host_byte_t wr_byte,
    output logic       rd_stb,
    output logic       rd_cmd
);
    pin_op_t    op_q;
    host_byte_t cap_q;
    logic       rd_sel_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            op_q     <= '0;
            cap_q    <= '0;
            rd_sel_q <= 1'b0;
            wr_stb   <= 1'b0;
            rd_stb   <= 1'b0;
        end else begin
            op_q   <= op_s;
            wr_stb <= op_q.wr && !op_s.wr;
            rd_stb <= op_q.rd && !op_s.rd;
            if (op_s.wr) cap_q    <= byte_s;
            if (op_s.rd) rd_sel_q <= byte_s.is_cmd;
        end
    end

    assign wr_byte = cap_q;
    assign rd_cmd  = rd_sel_q;

    // R2
    wr_single_chk: assert property (@(posedge clk) disable iff (rst)
        wr_stb |=> !wr_stb);

    // R8
    wr_rd_excl_chk: assert property (@(posedge clk) disable iff (rst)
        !(wr_stb && rd_stb));

    // R5
    rd_single_chk: assert property (@(posedge clk) disable iff (rst)
        rd_stb |=> !rd_stb);
endmodule

// File: rtl/hbus_busy.sv
module hbus_busy
    import hbus_pkg::*;
#(
    parameter logic [HB_CLS_W-1:0] MEM_CLASS = 4'h4
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       wr_stb,
    input  host_byte_t wr_byte,
    input  logic       slot_done,
    output logic       busy,
    output logic       overrun
);
    always_ff @(posedge clk) begin
        if (rst) begin
            busy    <= 1'b0;
            overrun <= 1'b0;
        end else begin
            overrun <= wr_stb && busy;
            if (wr_stb && is_mem_cmd(wr_byte, MEM_CLASS)) begin
                busy <= 1'b1;
            end else if (slot_done) begin
                busy <= 1'b0;
            end
        end
    end

    // R9
    busy_rise_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(busy) |-> $past(wr_stb) && $past(wr_byte.is_cmd));

    // R9
    busy_fall_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(busy) |-> $past(slot_done));

    // R10
    overrun_src_chk: assert property (@(posedge clk) disable iff (rst)
        overrun |-> $past(wr_stb) && $past(busy));
endmodule

// File: rtl/hbus_port.sv
module hbus_port
    import hbus_pkg::*;
#(
    parameter int                  SYNC_STAGES = 2,
    parameter logic [HB_CLS_W-1:0] MEM_CLASS   = 4'h4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             bus_fmt,
    input  logic             cs_n,
    input  logic             a0,
    input  logic             rd_e,
    input  logic             wr_rw,
    input  logic [HB_DW-1:0] d_in,
    output logic [HB_DW-1:0] d_out,
    output logic             d_oe,
    output logic             core_wr_stb,
    output logic             core_wr_cmd,
    output logic [HB_DW-1:0] core_wr_data,
    output logic             core_rd_stb,
    output logic             core_rd_cmd,
    input  logic [HB_DW-1:0] core_rd_data,
    input  logic             mem_slot_done,
    output logic             busy,
    output logic             overrun
);
    localparam int           CTRL_W   = 3;
    localparam logic [2:0]   CTRL_IDL = 3'b100;

    bus_fmt_e   fmt;
    pin_op_t    op_raw;
    pin_op_t    op_s;
    logic [CTRL_W-1:0] ctrl_s;
    host_byte_t byte_in;
    host_byte_t byte_s;
    host_byte_t wr_byte;

    assign fmt    = bus_fmt_e'(bus_fmt);
    assign op_raw = decode_pins(fmt, cs_n, rd_e, wr_rw);
    assign d_oe   = op_raw.rd;
    assign d_out  = op_raw.rd ? core_rd_data : '0;

    assign byte_in.is_cmd = a0;
    assign byte_in.data   = d_in;

    hbus_sync #(.W(CTRL_W), .STAGES(SYNC_STAGES), .RST_VAL(CTRL_IDL)) u_sync_ctrl (
        .clk (clk),
        .rst (rst),
        .d   ({cs_n, rd_e, wr_rw}),
        .q   (ctrl_s)
    );

    hbus_sync #(.W(HB_BYTE_W), .STAGES(SYNC_STAGES), .RST_VAL('0)) u_sync_byte (
        .clk (clk),
        .rst (rst),
        .d   (byte_in),
        .q   (byte_s)
    );

    assign op_s = decode_pins(fmt, ctrl_s[2], ctrl_s[1], ctrl_s[0]);

    hbus_edge_cap u_edge (
        .clk     (clk),
        .rst     (rst),
        .op_s    (op_s),
        .byte_s  (byte_s),
        .wr_stb  (core_wr_stb),
        .wr_byte (wr_byte),
        .rd_stb  (core_rd_stb),
        .rd_cmd  (core_rd_cmd)
    );

    assign core_wr_cmd  = wr_byte.is_cmd;
    assign core_wr_data = wr_byte.data;

    hbus_busy #(.MEM_CLASS(MEM_CLASS)) u_busy (
        .clk       (clk),
        .rst       (rst),
        .wr_stb    (core_wr_stb),
        .wr_byte   (wr_byte),
        .slot_done (mem_slot_done),
        .busy      (busy),
        .overrun   (overrun)
    );

    // R4
    oe_cs_chk: assert property (@(posedge clk) disable iff (rst)
        d_oe |-> !cs_n);
endmodule

// File: tb/hbus_port_tb.sv
module hbus_port_tb;
    localparam int SYNC = 2;
    localparam int LAT  = SYNC + 2;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       bus_fmt = 1'b0;
    logic       cs_n = 1'b1;
    logic       a0 = 1'b0;
    logic       rd_e = 1'b1;
    logic       wr_rw = 1'b1;
    logic [7:0] d_in = '0;
    logic [7:0] d_out;
    logic       d_oe;
    logic       core_wr_stb, core_wr_cmd, core_rd_stb, core_rd_cmd;
    logic [7:0] core_wr_data;
    logic [7:0] core_rd_data = '0;
    logic       mem_slot_done = 1'b0;
    logic       busy, overrun;

    int n_chk = 0, n_err = 0;
    int cyc = 0, n_wr = 0, n_rd = 0, n_ovr = 0, n_oe = 0;
    int mon_cyc = 0, t_rel = 0;
    logic [7:0] mon_d = '0;
    logic mon_cmd = 0, mon_rcmd = 0;

    always #2 clk = ~clk;

    hbus_port #(.SYNC_STAGES(SYNC), .MEM_CLASS(4'h4)) u_dut (
        .clk(clk), .rst(rst), .bus_fmt(bus_fmt), .cs_n(cs_n), .a0(a0),
        .rd_e(rd_e), .wr_rw(wr_rw), .d_in(d_in), .d_out(d_out), .d_oe(d_oe),
        .core_wr_stb(core_wr_stb), .core_wr_cmd(core_wr_cmd),
        .core_wr_data(core_wr_data), .core_rd_stb(core_rd_stb),
        .core_rd_cmd(core_rd_cmd), .core_rd_data(core_rd_data),
        .mem_slot_done(mem_slot_done), .busy(busy), .overrun(overrun)
    );

    always @(negedge clk) begin
        cyc++;
        if (!rst) begin
            if (core_wr_stb) begin
                n_wr++; mon_d = core_wr_data; mon_cmd = core_wr_cmd; mon_cyc = cyc;
            end
            if (core_rd_stb) begin n_rd++; mon_rcmd = core_rd_cmd; end
            if (overrun) n_ovr++;
            if (d_oe) n_oe++;
        end
    end

    task automatic check(string req, string what, int act, int exp);
        n_chk++;
        if (act != exp) begin
            n_err++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic tick(int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic do_reset(logic f);
        tick(1);
        rst = 1'b1; bus_fmt = f; cs_n = 1'b1; a0 = 1'b0;
        rd_e = f ? 1'b0 : 1'b1; wr_rw = 1'b1; mem_slot_done = 1'b0;
        tick(3);
        rst = 1'b0;
        tick(SYNC + 2);
    endtask

    task automatic host_write(logic a, logic [7:0] d, logic sel);
        tick(1);
        a0 = a; d_in = d; cs_n = !sel; wr_rw = 1'b0;
        if (bus_fmt) begin tick(1); rd_e = 1'b1; end
        tick(3);
        if (bus_fmt) rd_e = 1'b0; else wr_rw = 1'b1;
        t_rel = cyc;
        tick(1);
        wr_rw = 1'b1; cs_n = 1'b1;
        tick(SYNC + 5);
    endtask

    task automatic host_read(logic a, logic [7:0] v, logic sel);
        tick(1);
        core_rd_data = v; a0 = a; cs_n = !sel;
        if (bus_fmt) rd_e = 1'b1; else rd_e = 1'b0;
        @(negedge clk);
        check("R4", "d_oe during read", d_oe, sel);
        check("R4", "d_out during read", d_out, sel ? v : 8'h00);
        tick(2);
        if (bus_fmt) rd_e = 1'b0; else rd_e = 1'b1;
        @(negedge clk);
        check("R4", "d_oe after read", d_oe, 0);
        check("R4", "d_out after read", d_out, 0);
        tick(1);
        cs_n = 1'b1;
        tick(SYNC + 5);
    endtask

    task automatic slot_pulse();
        tick(1);
        mem_slot_done = 1'b1;
        tick(1);
        mem_slot_done = 1'b0;
        tick(1);
    endtask

    initial begin
        #(200000 * 4);
        n_err++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end

    initial begin
        do_reset(1'b0);
        @(negedge clk);
        // R1 reset state
        check("R1", "wr_stb", core_wr_stb, 0);
        check("R1", "rd_stb", core_rd_stb, 0);
        check("R1", "busy", busy, 0);
        check("R1", "overrun", overrun, 0);
        check("R1", "d_oe", d_oe, 0);
        check("R1", "d_out", d_out, 0);

        for (int f = 0; f < 2; f++) begin
            do_reset(f[0]);
            for (int a = 0; a < 2; a++) begin
                for (int d = 0; d < 256; d++) begin
                    int  w0, o0, e0;
                    bit  mem;
                    mem = (a == 1) && (d[7:4] == 4'h4);
                    w0 = n_wr; o0 = n_ovr; e0 = n_oe;
                    host_write(a[0], d[7:0], 1'b1);
                    check(f ? "R3" : "R2", "pulse count", n_wr - w0, 1);
                    check(f ? "R3" : "R2", "data", mon_d, d);
                    check(f ? "R3" : "R2", "cmd tag", mon_cmd, a);
                    check("R6", "latency", mon_cyc - t_rel, LAT);
                    check("R4", "no d_oe on write", n_oe - e0, 0);
                    check("R10", "no overrun when idle", n_ovr - o0, 0);
                    if (a == 0) check("R11", "param no busy", busy, 0);
                    else        check("R9", "busy after cmd", busy, mem);
                    if (mem) begin
                        w0 = n_wr;
                        host_write(1'b0, ~d[7:0], 1'b1);
                        check("R10", "forwarded while busy", n_wr - w0, 1);
                        check("R10", "forwarded data", mon_d, (~d) & 8'hff);
                        check("R10", "overrun raised", n_ovr - o0, 1);
                        check("R9", "busy held", busy, 1);
                        slot_pulse();
                        check("R9", "busy cleared", busy, 0);
                    end
                end
            end

            // R5 and R4 reads
            for (int k = 0; k < 6; k++) begin
                int r0, w0;
                r0 = n_rd; w0 = n_wr;
                host_read(k[0], 8'(8'h3c + k * 37), 1'b1);
                check("R5", "read pulse", n_rd - r0, 1);
                check("R5", "read tag", mon_rcmd, k & 1);
                check("R5", "no write on read", n_wr - w0, 0);
            end

            // R7 chip select high
            begin
                int r0, w0, e0;
                r0 = n_rd; w0 = n_wr; e0 = n_oe;
                host_write(1'b1, 8'h41, 1'b0);
                host_read(1'b0, 8'h99, 1'b0);
                check("R7", "no write pulse", n_wr - w0, 0);
                check("R7", "no read pulse", n_rd - r0, 0);
                check("R7", "no d_oe", n_oe - e0, 0);
                check("R7", "busy untouched", busy, 0);
            end
        end

        // R8 both strobes low in strobe style
        do_reset(1'b0);
        begin
            int r0, w0, e0;
            r0 = n_rd; w0 = n_wr; e0 = n_oe;
            tick(1);
            a0 = 1'b1; d_in = 8'h42; cs_n = 1'b0; rd_e = 1'b0; wr_rw = 1'b0;
            tick(4);
            rd_e = 1'b1; wr_rw = 1'b1;
            tick(1);
            cs_n = 1'b1;
            tick(SYNC + 5);
            check("R8", "no write pulse", n_wr - w0, 0);
            check("R8", "no read pulse", n_rd - r0, 0);
            check("R8", "no d_oe", n_oe - e0, 0);
            check("R8", "busy untouched", busy, 0);
        end

        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end
endmodule